// File: doc/BRIEF.md
# I2C Configuration Register Target for a Four-Channel Clock Distributor

This block is the serial control port of a clock distribution unit. It listens on a two-wire I2C bus as a target with a fixed 7-bit device address, keeps one global configuration byte and one configuration byte for each output channel, and drives those bytes continuously to the clock gating controller beside it. It also offers a status byte assembled at read time from a sticky over-temperature flag and the live request levels that the gating controller produces.

A host changes a register by sending the device address with the write direction, a register pointer byte, and a data byte. The change appears on the configuration outputs at the rising SCL edge of the acknowledge that follows the data byte. To read, the host writes the pointer, issues a repeated start, sends the address with the read direction, and clocks in the selected register. There is no pointer auto-increment: further bytes in the same transaction reuse the same register. SDA is open-drain and is modelled as a pull-low enable. SCL and SDA are synchronised to the system clock, which must run at least eight times faster than SCL. Every port is a plain level signal. The configuration bytes are state and are always valid, so the block has no valid/ready stream and nothing to apply back-pressure to.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target acknowledges (pulls SDA low on the ninth clock) only an address byte whose upper seven bits equal 0x38. For any other address it leaves SDA released and ignores the rest of the transaction.
- R2: A write of address (bit 0 = 0), pointer and data is acknowledged on every byte. After it, the addressed register reads back the data byte, and the configuration outputs show it: cfg_o for pointer 0x00, chan_cfg_o[8*(n-1)+:8] for pointer n = 0x01..0x04.
- R3: A pointer write, a repeated start and an address byte with bit 0 = 1 return the selected register MSB first. Further bytes acknowledged by the host in the same read return the same register.
- R4: After reset, register 0x00 (cfg_o) is 0x44, registers 0x01..0x04 are 0x06, and the thermal flag is clear.
- R5: Reserved bits are held at zero: bit 7 of register 0x00 and bits 7:6 of registers 0x01..0x04, whatever value is written.
- R6: Register 0x05 reads {2'b00, up_req_i, chan_req_i[3:0], thermal flag}, with the flag in bit 0, channel n in bit n and the upstream request in bit 5. A write to it is acknowledged and has no effect.
- R7: A one-cycle pulse on thermal_evt_i sets the thermal flag on the next clock. The flag stays set through any bus traffic until reset.
- R8: Writes to pointers 0x06..0xFF are acknowledged and change no register. Reads from those pointers return 0x00.
- R9: The target changes its SDA drive only on the system clock after a falling SCL edge, a start or a stop is detected, and it always releases SDA after a stop.
- R10: The configuration outputs change only on the system clock after a rising SCL edge is detected. A written value is not visible before the rising edge of the final acknowledge and is visible right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| thermal_evt_i | input | 1 | Over-temperature event pulse |
| chan_req_i | input | NUM_CH | Live per-channel request levels from the gating controller |
| up_req_i | input | 1 | Live upstream source request level |
| cfg_o | output | 8 | Global configuration register |
| chan_cfg_o | output | 8*NUM_CH | Per-channel configuration registers, channel 1 in the low byte |

## Verification
The bench builds the block with its defaults: four channels, device address 0x38 and a two-stage synchroniser. With those values the pointer space that matters is small, so the bench sweeps every pointer from 0x00 to 0x07 with four data patterns, covering all mapped, status and unmapped cases, and reads back each one. It also runs through all 32 combinations of the five live request inputs in the status byte. The short bus period of about 20 system clocks per SCL cycle lets it sample the configuration outputs on either side of the final acknowledge's rising edge on every write.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } bus_st_e;

  localparam logic [7:0] GLOBAL_RST  = 8'h44;
  localparam logic [7:0] CHAN_RST    = 8'h06;
  localparam logic [7:0] GLOBAL_MASK = 8'h7F;
  localparam logic [7:0] CHAN_MASK   = 8'h3F;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_raw};
      sda_ff <= {sda_ff[STAGES-2:0], sda_raw};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_target_seq.sv
module i2c_target_seq
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h38
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data
);

  bus_st_e    st;
  logic [3:0] cnt;
  logic [7:0] shreg, txreg;
  logic       rd_mode, mack;

  assign wr_en   = (st == ST_WDAT_ACK) && scl_rise;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txreg    <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      rd_mode  <= 1'b0;
      mack     <= 1'b0;
    end else if (start_evt) begin
      st       <= ST_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_pull <= 1'b1;
                rd_mode  <= shreg[0];
                st       <= ST_ADDR_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end else if (st == ST_PTR) begin
              sda_pull <= 1'b1;
              st       <= ST_PTR_ACK;
            end else begin
              sda_pull <= 1'b1;
              st       <= ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd_mode) begin
              txreg    <= rd_data;
              sda_pull <= ~rd_data[7];
              st       <= ST_RDAT;
            end else begin
              sda_pull <= 1'b0;
              st       <= ST_PTR;
            end
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall) begin
            ptr      <= shreg;
            sda_pull <= 1'b0;
            st       <= ST_WDAT;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              cnt      <= '0;
              sda_pull <= 1'b0;
              st       <= ST_RACK;
            end else begin
              txreg    <= {txreg[6:0], 1'b0};
              sda_pull <= ~txreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              txreg    <= rd_data;
              sda_pull <= ~rd_data[7];
              st       <= ST_RDAT;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          ptr,
  input  logic [7:0]          wr_data,
  input  logic                thermal_evt,
  input  logic [NUM_CH-1:0]   chan_req,
  input  logic                up_req,
  output logic [7:0]          cfg_o,
  output logic [NUM_CH*8-1:0] chan_cfg_o,
  output logic [7:0]          rd_data,
  output logic                therm_flag
);

  localparam int         STAT_W    = NUM_CH + 2;
  localparam logic [7:0] STAT_ADDR = 8'(NUM_CH + 1);

  logic [STAT_W-1:0] stat_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= GLOBAL_RST;
    end else if (wr_en && ptr == 8'h00) begin
      cfg_o <= wr_data & GLOBAL_MASK;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_cfg_o[g*8 +: 8] <= CHAN_RST;
      end else if (wr_en && ptr == 8'(g + 1)) begin
        chan_cfg_o[g*8 +: 8] <= wr_data & CHAN_MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_flag <= 1'b0;
    end else if (thermal_evt) begin
      therm_flag <= 1'b1;
    end
  end

  assign stat_bits = {up_req, chan_req, therm_flag};

  always_comb begin
    rd_data = 8'h00;
    if (ptr == 8'h00) rd_data = cfg_o;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ptr == 8'(i + 1)) rd_data = chan_cfg_o[i*8 +: 8];
    end
    if (ptr == STAT_ADDR) rd_data = 8'(stat_bits);
  end

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int         NUM_CH      = 4,
  parameter logic [6:0] DEV_ADDR    = 7'h38,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  input  logic                thermal_evt_i,
  input  logic [NUM_CH-1:0]   chan_req_i,
  input  logic                up_req_i,
  output logic [7:0]          cfg_o,
  output logic [NUM_CH*8-1:0] chan_cfg_o
);

  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] ptr, wr_data, rd_data;
  logic       wr_en, therm_flag;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_target_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull_o),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  cfg_regbank #(.NUM_CH(NUM_CH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .ptr         (ptr),
    .wr_data     (wr_data),
    .thermal_evt (thermal_evt_i),
    .chan_req    (chan_req_i),
    .up_req      (up_req_i),
    .cfg_o       (cfg_o),
    .chan_cfg_o  (chan_cfg_o),
    .rd_data     (rd_data),
    .therm_flag  (therm_flag)
  );

endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_rise,
  input logic                scl_fall,
  input logic                start_evt,
  input logic                stop_evt,
  input logic                sda_pull_o,
  input logic [7:0]          cfg_o,
  input logic [NUM_CH*8-1:0] chan_cfg_o,
  input logic                therm_flag,
  input logic                thermal_evt_i
);

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(scl_fall || start_evt || stop_evt));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_o);

  // R10
  global_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(scl_rise));

  // R10
  chan_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_cfg_o) |-> $past(scl_rise));

  // R7
  therm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_evt_i |=> therm_flag);

  // R7
  therm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flag |=> therm_flag);

endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_rise      (scl_rise),
  .scl_fall      (scl_fall),
  .start_evt     (start_evt),
  .stop_evt      (stop_evt),
  .sda_pull_o    (sda_pull_o),
  .cfg_o         (cfg_o),
  .chan_cfg_o    (chan_cfg_o),
  .therm_flag    (therm_flag),
  .thermal_evt_i (thermal_evt_i)
);

// File: tb/sim_cfg_i2c_target.sv
`timescale 1ns/1ps
module sim_cfg_i2c_target;
  localparam int NCH = 4;
  localparam int Q   = 50;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, m_scl, m_sda, thermal_evt, up_req;
  logic [NCH-1:0]   chan_req;
  logic             sda_pull;
  wire              sda_bus;
  logic [7:0]       cfg_o;
  logic [NCH*8-1:0] chan_cfg_o;

  assign sda_bus = m_sda & ~sda_pull;

  cfg_i2c_target #(.NUM_CH(NCH)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (m_scl),
    .sda_i         (sda_bus),
    .sda_pull_o    (sda_pull),
    .thermal_evt_i (thermal_evt),
    .chan_req_i    (chan_req),
    .up_req_i      (up_req),
    .cfg_o         (cfg_o),
    .chan_cfg_o    (chan_cfg_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_cfg;
  logic [7:0] m_ch [NCH];
  bit m_therm;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int a);
    if (a == 0) return m_cfg;
    if (a >= 1 && a <= NCH) return m_ch[a-1];
    if (a == NCH + 1) return {2'b00, up_req, chan_req, m_therm};
    return 8'h00;
  endfunction

  function automatic logic [7:0] out_reg(input int a);
    if (a == 0) return cfg_o;
    return chan_cfg_o[(a-1)*8 +: 8];
  endfunction

  task automatic model_reset();
    m_cfg = 8'h44;
    for (int i = 0; i < NCH; i++) m_ch[i] = 8'h06;
    m_therm = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b);
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; ack = ~sda_bus; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; b[i] = sda_bus; #Q; m_scl = 1'b0; #Q;
    end
    m_sda = ~mack; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
  endtask

  task automatic reg_write(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d,
                           output bit k0, output bit k1, output bit k2);
    bit hit;
    hit = (dev == 7'h38) && (a <= 8'(NCH));
    bus_start();
    send_byte({dev, 1'b0}, k0);
    send_byte(a, k1);
    send_bits(d);
    m_sda = 1'b1; #Q;
    if (hit) check("R10 value unchanged before final ack rise", out_reg(int'(a)), exp_reg(int'(a)));
    m_scl = 1'b1; #Q;
    k2 = ~sda_bus;
    if (dev == 7'h38) begin
      if (a == 8'h00) m_cfg = d & 8'h7F;
      else if (a <= 8'(NCH)) m_ch[a-1] = d & 8'h3F;
    end
    if (hit) check("R10 value visible after final ack rise", out_reg(int'(a)), exp_reg(int'(a)));
    #Q; m_scl = 1'b0; #Q;
    bus_stop();
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d, output bit ok);
    bit k0, k1, k2;
    bus_start();
    send_byte({7'h38, 1'b0}, k0);
    send_byte(a, k1);
    bus_start();
    send_byte({7'h38, 1'b1}, k2);
    recv_byte(1'b0, d);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, rd2, pat;
    bit ok, k0, k1, k2;
    logic [7:0] pats [4];
    string tag;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;

    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    thermal_evt = 1'b0; chan_req = '0; up_req = 1'b0;
    model_reset();
    #52; rst_n = 1'b1; #100;

    // R4 reset state at the ports
    check("R4 global reset value", cfg_o, 8'h44);
    for (int c = 1; c <= NCH; c++) check("R4 channel reset value", out_reg(c), 8'h06);
    check("R9 SDA released at idle", 8'(sda_bus), 8'h01);

    // R4 / R8 / R6 read every pointer after reset
    for (int a = 0; a < 8; a++) begin
      reg_read(8'(a), rd, ok);
      check("R1 address 0x38 acknowledged", 8'(ok), 8'h01);
      check(a <= NCH ? "R4 reset readback" : (a == NCH + 1 ? "R6 status readback" : "R8 unmapped reads zero"),
            rd, exp_reg(a));
    end

    // R2 / R5 / R6 / R8 sweep of pointers and data patterns
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 8; a++) begin
        pat = pats[p] ^ 8'(a);
        reg_write(7'h38, 8'(a), pat, k0, k1, k2);
        tag = (a <= NCH) ? "R2 write acknowledged" : (a == NCH + 1 ? "R6 status write acknowledged" : "R8 unmapped write acknowledged");
        check(tag, 8'({k0, k1, k2}), 8'h07);
        reg_read(8'(a), rd, ok);
        if (a <= NCH && (pat[7] || (a > 0 && pat[6]))) tag = "R5 reserved bits read zero";
        else if (a <= NCH) tag = "R2 readback";
        else if (a == NCH + 1) tag = "R6 status write ignored";
        else tag = "R8 unmapped write ignored";
        check(tag, rd, exp_reg(a));
      end
    end
    check("R2 global output", cfg_o, m_cfg);
    for (int c = 1; c <= NCH; c++) check("R2 channel output", out_reg(c), m_ch[c-1]);
    check("R9 SDA released after stop", 8'(sda_bus), 8'h01);

    // R1 foreign addresses: no acknowledge, no change
    reg_write(7'h39, 8'h00, 8'h11, k0, k1, k2);
    check("R1 address 0x39 not acknowledged", 8'(k0), 8'h00);
    reg_write(7'h1C, 8'h02, 8'h22, k0, k1, k2);
    check("R1 address 0x1C not acknowledged", 8'(k0), 8'h00);
    check("R1 global unchanged by foreign write", cfg_o, m_cfg);
    check("R1 channel 2 unchanged by foreign write", out_reg(2), m_ch[1]);

    // R3 repeated bytes of one read return the same register
    reg_write(7'h38, 8'h03, 8'h2B, k0, k1, k2);
    bus_start();
    send_byte({7'h38, 1'b0}, k0);
    send_byte(8'h03, k1);
    bus_start();
    send_byte({7'h38, 1'b1}, k2);
    recv_byte(1'b1, rd);
    recv_byte(1'b0, rd2);
    bus_stop();
    check("R3 first read byte", rd, 8'h2B);
    check("R3 second read byte same register", rd2, 8'h2B);
    bus_start();
    send_byte({7'h38, 1'b1}, k0);
    recv_byte(1'b0, rd);
    bus_stop();
    check("R3 read without new pointer keeps pointer", rd, 8'h2B);

    // R6 all live request combinations
    for (int v = 0; v < 32; v++) begin
      chan_req = v[3:0]; up_req = v[4];
      reg_read(8'(NCH + 1), rd, ok);
      check("R6 status live bits", rd, exp_reg(NCH + 1));
    end

    // R7 sticky thermal flag
    chan_req = 4'b0000; up_req = 1'b0;
    thermal_evt = 1'b1; #10; thermal_evt = 1'b0; m_therm = 1'b1;
    reg_read(8'(NCH + 1), rd, ok);
    check("R7 thermal flag set", rd, 8'h01);
    reg_write(7'h38, 8'(NCH + 1), 8'h00, k0, k1, k2);
    reg_write(7'h38, 8'h00, 8'h3C, k0, k1, k2);
    chan_req = 4'b1010; up_req = 1'b1;
    reg_read(8'(NCH + 1), rd, ok);
    check("R7 thermal flag sticky with live bits", rd, 8'h35);

    // R4 reset restores defaults and clears the flag
    #3; rst_n = 1'b0; #20; rst_n = 1'b1; #97;
    model_reset();
    check("R4 global after reset", cfg_o, 8'h44);
    check("R4 channel 4 after reset", out_reg(4), 8'h06);
    reg_read(8'(NCH + 1), rd, ok);
    check("R7 thermal flag cleared by reset", rd, 8'h34);
    reg_read(8'h01, rd, ok);
    check("R4 channel 1 readback after reset", rd, 8'h06);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule